// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

The block pairs a free-running up-counter with a compare register of the same width. Whenever the running count equals the compare value and a compare mode is selected, a compare event fires. The mode picks what the event does: set the output latch, clear it, raise only the interrupt flag, or fire the special event trigger. The special event trigger clears the counter and sends a one-cycle start pulse to an external converter. In that mode the compare register sets the period of the counter, which counts from 0 up to the compare value.

Software reaches the block through a small register port with four addresses:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | count | the counter value |
| 1 | compare | the compare value |
| 2 | control | bits [3:0] mode, bit 4 output enable, bit 5 run |
| 3 | flags | bit 0 compare flag, bit 1 overflow flag |

Writes take effect at the clock edge. Reads are combinational.

The output latch drives `pin_drv_o`. The output-enable bit drives `pin_oe_o`, and when it is low the pin is treated as high-impedance. The interrupt output follows the compare flag.

A small state machine makes sure that a match fires once for each count value. It has three states.

- ST_OFF: the mode field holds no valid mode.
- ST_ARMED: the current count has not yet produced its event.
- ST_HELD: the current count has already fired.

It has these transitions.

- From ST_OFF to ST_ARMED when a valid mode appears.
- From ST_OFF or ST_ARMED to ST_HELD on a compare event at a clock edge where the count does not change.
- From ST_HELD to ST_ARMED on a rearm: the counter loads a new value, or software writes the compare register.
- From any state to ST_OFF when the mode field becomes invalid.

An event may fire in ST_OFF or ST_ARMED, but never in ST_HELD.

Top module: `tcu_top`

## Requirements
- R1: After reset the count, compare, control and flag registers read 0, and `pin_drv_o`, `pin_oe_o`, `irq_o` and `conv_start_o` are low.
- R2: While control bit 5 (run) is 1, the counter increments once per clock. A write to address 0 loads the counter, and this load takes priority over both the increment and the trigger reset. Reads return count at address 0, compare at 1, control bits [5:0] at 2 and flags bits [1:0] at 3.
- R3: When the counter wraps from all ones to 0 while running, the overflow flag (flags bit 1) is set.
- R4: A compare event happens at a clock edge where the mode is valid, the count equals the compare value and the state is not ST_HELD. It sets the compare flag (flags bit 0), which becomes visible in the cycle after that edge. `irq_o` equals this flag. The flag stays set until a flags write loads 0 into it, and a hardware set in the same cycle wins over that write.
- R5: Mode 4'b1000 sets the output latch on a compare event. Mode 4'b1001 clears it.
- R6: Mode 4'b1010 sets only the compare flag and leaves the output latch unchanged.
- R7: In mode 4'b1011 a compare event loads 0 into the counter at the same edge, so the period is compare+1 clocks. This reset never sets the overflow flag, including when the compare value is all ones.
- R8: In mode 4'b1011, `conv_start_o` is high for the one cycle after a compare event, and only if `adc_en_i` was high at that edge. The counter reset takes place whatever the value of `adc_en_i`.
- R9: A mode field outside 4'b10xx produces no compare event: the flag does not change, the latch does not change and the counter is not reset.
- R10: While the counter holds one value, a match fires only once. A new count value or a write to the compare register rearms the match.
- R11: A control write whose mode field is 4'b0000 forces the output latch to 0, and this takes priority over a same-cycle compare event.
- R12: `pin_oe_o` equals control bit 4, and `pin_drv_o` always shows the output latch. The latch keeps updating while the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 count, 1 compare, 2 control, 3 flags) |
| wdata | input | W (16) | Write data |
| rdata | output | W (16) | Read data for `addr` |
| adc_en_i | input | 1 | The external converter is enabled |
| pin_drv_o | output | 1 | Output latch value for the pin driver |
| pin_oe_o | output | 1 | Pin driver enable; low means the pin is high-impedance |
| irq_o | output | 1 | Compare interrupt flag |
| conv_start_o | output | 1 | Conversion start pulse |

## Verification
The assertions check the following on every cycle:
- The compare flag rises only after an event or a flags write.
- The output latch moves only on an event or a zero-mode control write, and never in interrupt-only mode.
- A trigger event always brings the counter to 0 without touching the overflow flag.
- The start pulse always follows a trigger event that happened with the converter enabled.
- The overflow flag rises only from a wrap at all ones.
- No two events fire back to back without a rearm.

Only the bench scenarios can show the exact cycle at which each output changes. They also show:
- the trigger period of compare+1 clocks for random compare values;
- that a stopped counter stays quiet after its single event;
- that a disabled driver still lets the latch follow compare events;
- that invalid modes leave the flags, the latch and the count unchanged.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    localparam int MODE_W       = 4;
    localparam int CTRL_W       = 6;
    localparam int CTRL_OE_BIT  = 4;
    localparam int CTRL_RUN_BIT = 5;
    localparam int FLAG_W       = 2;
    localparam int FLAG_CMP     = 0;
    localparam int FLAG_OVF     = 1;
    localparam int ADDR_W       = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_SET  = 4'b1000,
        MODE_CLR  = 4'b1001,
        MODE_IRQ  = 4'b1010,
        MODE_TRIG = 4'b1011
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } cmp_state_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_COUNT   = 2'd0,
        REG_COMPARE = 2'd1,
        REG_CONTROL = 2'd2,
        REG_FLAGS   = 2'd3
    } reg_addr_e;

    function automatic logic mode_valid(input logic [MODE_W-1:0] m);
        return m[MODE_W-1:MODE_W-2] == 2'b10;
    endfunction

endpackage

// File: rtl/tcu_counter.sv
module tcu_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         trig_clear,
    output logic [W-1:0] count,
    output logic         wrap,
    output logic         advance
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (trig_clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // A wrap counts only when the increment really happens.
    assign wrap    = run && !load_en && !trig_clear && (cnt_q == ALL_ONES);
    assign advance = run || load_en || trig_clear;
    assign count   = cnt_q;

endmodule

// File: rtl/tcu_regfile.sv
module tcu_regfile
    import tcu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      count,
    input  logic [FLAG_W-1:0] flag_set,
    output logic [W-1:0]      compare,
    output logic [MODE_W-1:0] mode,
    output logic              oe,
    output logic              run,
    output logic [FLAG_W-1:0] flags,
    output logic [W-1:0]      rdata,
    output logic              cnt_wr,
    output logic              cmp_wr,
    output logic              ctrl_zero_wr
);

    logic [W-1:0]      cmp_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              ctrl_wr;
    logic              flag_wr;

    assign cnt_wr       = wr_en && (addr == REG_COUNT);
    assign cmp_wr       = wr_en && (addr == REG_COMPARE);
    assign ctrl_wr      = wr_en && (addr == REG_CONTROL);
    assign flag_wr      = wr_en && (addr == REG_FLAGS);
    assign ctrl_zero_wr = ctrl_wr && (wdata[MODE_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (cmp_wr) begin
                cmp_q <= wdata;
            end
            if (ctrl_wr) begin
                ctrl_q <= wdata[CTRL_W-1:0];
            end
        end
    end

    // One sticky flag per event source; a hardware set wins over a write.
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (flag_set[i]) begin
                bit_q <= 1'b1;
            end else if (flag_wr) begin
                bit_q <= wdata[i];
            end
        end
        assign flags[i] = bit_q;
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            REG_COUNT:   rdata = count;
            REG_COMPARE: rdata = cmp_q;
            REG_CONTROL: rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            REG_FLAGS:   rdata = {{(W-FLAG_W){1'b0}}, flags};
            default:     rdata = '0;
        endcase
    end

    assign compare = cmp_q;
    assign mode    = ctrl_q[MODE_W-1:0];
    assign oe      = ctrl_q[CTRL_OE_BIT];
    assign run     = ctrl_q[CTRL_RUN_BIT];

endmodule

// File: rtl/tcu_cmp_fsm.sv
module tcu_cmp_fsm
    import tcu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      count,
    input  logic [W-1:0]      compare,
    input  logic [MODE_W-1:0] mode,
    input  logic              rearm,
    input  logic              ctrl_zero_wr,
    input  logic              adc_en,
    output logic              fire,
    output logic              trig_clear,
    output logic              latch,
    output logic              conv_start
);

    cmp_state_e state_q;
    cmp_state_e state_n;
    logic       mode_ok;
    logic       equal;

    assign mode_ok    = mode_valid(mode);
    assign equal      = (count == compare);
    assign fire       = mode_ok && equal && (state_q != ST_HELD);
    assign trig_clear = fire && (mode == MODE_TRIG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (mode_ok) begin
                    state_n = (fire && !rearm) ? ST_HELD : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!mode_ok) begin
                    state_n = ST_OFF;
                end else if (fire && !rearm) begin
                    state_n = ST_HELD;
                end
            end
            ST_HELD: begin
                if (!mode_ok) begin
                    state_n = ST_OFF;
                end else if (rearm) begin
                    state_n = ST_ARMED;
                end
            end
            default: state_n = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch      <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= trig_clear && adc_en;
            if (ctrl_zero_wr) begin
                latch <= 1'b0;
            end else if (fire && (mode == MODE_SET)) begin
                latch <= 1'b1;
            end else if (fire && (mode == MODE_CLR)) begin
                latch <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tcu_top.sv
module tcu_top
    import tcu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              adc_en_i,
    output logic              pin_drv_o,
    output logic              pin_oe_o,
    output logic              irq_o,
    output logic              conv_start_o
);

    logic [W-1:0]      cnt_val;
    logic [W-1:0]      cmp_val;
    logic [MODE_W-1:0] mode_val;
    logic              oe_val;
    logic              run_val;
    logic [FLAG_W-1:0] flags_val;
    logic [FLAG_W-1:0] flag_set;
    logic              cnt_wr;
    logic              cmp_wr;
    logic              ctrl_zero_wr;
    logic              fire;
    logic              trig_clear;
    logic              wrap;
    logic              cnt_adv;
    logic              rearm;
    logic              latch_val;

    assign flag_set[FLAG_CMP] = fire;
    assign flag_set[FLAG_OVF] = wrap;
    assign rearm              = cnt_adv || cmp_wr;

    tcu_regfile #(.W(W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .count        (cnt_val),
        .flag_set     (flag_set),
        .compare      (cmp_val),
        .mode         (mode_val),
        .oe           (oe_val),
        .run          (run_val),
        .flags        (flags_val),
        .rdata        (rdata),
        .cnt_wr       (cnt_wr),
        .cmp_wr       (cmp_wr),
        .ctrl_zero_wr (ctrl_zero_wr)
    );

    tcu_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_val),
        .load_en    (cnt_wr),
        .load_val   (wdata),
        .trig_clear (trig_clear),
        .count      (cnt_val),
        .wrap       (wrap),
        .advance    (cnt_adv)
    );

    tcu_cmp_fsm #(.W(W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .count        (cnt_val),
        .compare      (cmp_val),
        .mode         (mode_val),
        .rearm        (rearm),
        .ctrl_zero_wr (ctrl_zero_wr),
        .adc_en       (adc_en_i),
        .fire         (fire),
        .trig_clear   (trig_clear),
        .latch        (latch_val),
        .conv_start   (conv_start_o)
    );

    assign pin_drv_o = latch_val;
    assign pin_oe_o  = oe_val;
    assign irq_o     = flags_val[FLAG_CMP];

endmodule

// File: rtl/tcu_chk.sv
module tcu_chk
    import tcu_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      count,
    input logic [MODE_W-1:0] mode,
    input logic              adc_en_i,
    input logic              fire,
    input logic              rearm,
    input logic              latch,
    input logic              ctrl_zero_wr,
    input logic              conv_start_o,
    input logic              irq_o,
    input logic              ovf_flag
);

    logic flag_wr;
    logic cnt_wr;
    assign flag_wr = wr_en && (addr == REG_FLAGS);
    assign cnt_wr  = wr_en && (addr == REG_COUNT);

    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(fire) || $past(flag_wr)));

    // R4
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq_o);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_flag) && !$past(flag_wr)) |-> ($past(count) == {W{1'b1}}));

    // R7
    trig_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (mode == MODE_TRIG) && !cnt_wr) |=> (count == '0));

    // R7
    trig_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (mode == MODE_TRIG) && !flag_wr) |=> $stable(ovf_flag));

    // R8
    conv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> ($past(fire) && ($past(mode) == MODE_TRIG) && $past(adc_en_i)));

    // R5
    latch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch) |-> ($past(fire) || $past(ctrl_zero_wr)));

    // R6
    irq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (mode == MODE_IRQ) && !ctrl_zero_wr) |=> $stable(latch));

    // R11
    zero_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero_wr |=> !latch);

    // R10
    once_per_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !rearm) |=> !fire);

endmodule

bind tcu_top tcu_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .count        (cnt_val),
    .mode         (mode_val),
    .adc_en_i     (adc_en_i),
    .fire         (fire),
    .rearm        (rearm),
    .latch        (latch_val),
    .ctrl_zero_wr (ctrl_zero_wr),
    .conv_start_o (conv_start_o),
    .irq_o        (irq_o),
    .ovf_flag     (flags_val[1])
);

// File: tb/tcu_top_test.sv
module tcu_top_test;

    localparam int W = 16;
    localparam logic [1:0] A_CNT = 2'd0, A_CMP = 2'd1, A_CTL = 2'd2, A_FLG = 2'd3;
    // control values: {run, oe, mode}
    localparam logic [15:0] STOP = 16'h0007;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         adc_en_i = 1'b0;
    logic         pin_drv_o, pin_oe_o, irq_o, conv_start_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    tcu_top #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .adc_en_i(adc_en_i), .pin_drv_o(pin_drv_o),
        .pin_oe_o(pin_oe_o), .irq_o(irq_o), .conv_start_o(conv_start_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic exp_latch(input logic prev, input logic [3:0] m);
        if (m == 4'b1000) return 1'b1;
        if (m == 4'b1001) return 1'b0;
        return prev;
    endfunction

    function automatic logic [15:0] ctl(input logic run, input logic oe, input logic [3:0] m);
        return {10'd0, run, oe, m};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [W-1:0] c0, input logic [W-1:0] cmp);
        wr(A_CTL, STOP);
        wr(A_CNT, c0);
        wr(A_CMP, cmp);
        wr(A_FLG, 16'h0000);
    endtask

    logic [W-1:0] v;
    logic         pin_model;
    int           seed_junk;

    initial begin
        seed_junk = $urandom(32'd20240611);
        waitn(3);
        // R1 reset state
        rd(A_CNT, v); check("R1 count", v, 0);
        rd(A_CMP, v); check("R1 compare", v, 0);
        rd(A_CTL, v); check("R1 control", v, 0);
        rd(A_FLG, v); check("R1 flags", v, 0);
        check("R1 outputs", {12'd0, pin_drv_o, pin_oe_o, irq_o, conv_start_o}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 load, read and count
        wr(A_CNT, 16'h0005);
        rd(A_CNT, v); check("R2 load", v, 16'h0005);
        wr(A_CMP, 16'h1234);
        rd(A_CMP, v); check("R2 compare read", v, 16'h1234);
        wr(A_CTL, ctl(1, 0, 4'b0111));
        waitn(9);
        rd(A_CNT, v); check("R2 counting", v, 16'h000E);
        rd(A_CTL, v); check("R2 control read", v, 16'h0027);

        // R3 wrap sets overflow
        setup(16'hFFFE, 16'h0000);
        wr(A_CTL, ctl(1, 0, 4'b0111));
        waitn(1);
        rd(A_FLG, v); check("R3 before wrap", v, 0);
        waitn(1);
        rd(A_CNT, v); check("R3 wrap count", v, 0);
        rd(A_FLG, v); check("R3 overflow flag", v, 16'h0002);

        // R5 set mode, R4 flag timing
        setup(16'h0000, 16'd10);
        wr(A_CTL, ctl(1, 1, 4'b1000));
        waitn(10);
        check("R5 pin before match", pin_drv_o, 0);
        check("R4 irq before match", irq_o, 0);
        waitn(1);
        check("R5 pin set", pin_drv_o, 1);
        check("R4 irq set", irq_o, 1);
        check("R12 oe on", pin_oe_o, 1);
        waitn(5);
        check("R4 irq sticky", irq_o, 1);

        // R6 interrupt only: latch stays 1
        setup(16'h0000, 16'd3);
        wr(A_CTL, ctl(1, 1, 4'b1010));
        waitn(6);
        check("R6 latch kept", pin_drv_o, 1);
        check("R6 flag", irq_o, 1);
        wr(A_FLG, 16'h0000);
        check("R4 flag cleared by write", irq_o, 0);

        // R5 clear mode
        setup(16'h0000, 16'd4);
        wr(A_CTL, ctl(1, 1, 4'b1001));
        waitn(4);
        check("R5 pin before clear", pin_drv_o, 1);
        waitn(1);
        check("R5 pin cleared", pin_drv_o, 0);

        // R12 driver disabled, latch still follows
        setup(16'h0000, 16'd2);
        wr(A_CTL, ctl(1, 0, 4'b1000));
        waitn(4);
        check("R12 oe off", pin_oe_o, 0);
        wr(A_CTL, ctl(0, 1, 4'b1010));
        check("R12 latch updated while disabled", pin_drv_o, 1);
        check("R12 oe back on", pin_oe_o, 1);

        // R11 zero-mode control write forces latch low
        wr(A_CTL, 16'h0000);
        wr(A_CTL, ctl(0, 1, 4'b0111));
        check("R11 latch forced low", pin_drv_o, 0);

        // R10 once per value with stopped counter
        setup(16'd3, 16'd3);
        wr(A_CTL, ctl(0, 0, 4'b1010));
        waitn(2);
        check("R10 first fire", irq_o, 1);
        wr(A_FLG, 16'h0000);
        waitn(5);
        check("R10 no refire", irq_o, 0);
        wr(A_CMP, 16'd3);
        waitn(2);
        check("R10 rearm by compare write", irq_o, 1);

        // R9 invalid modes
        setup(16'd3, 16'd3);
        wr(A_CTL, ctl(0, 1, 4'b0101));
        waitn(5);
        rd(A_FLG, v); check("R9 no flag stopped", v, 0);
        setup(16'd0, 16'd2);
        wr(A_CTL, ctl(1, 1, 4'b1100));
        waitn(10);
        rd(A_FLG, v); check("R9 no flag running", v, 0);
        rd(A_CNT, v); check("R9 no reset", v, 16'd10);
        check("R9 latch unchanged", pin_drv_o, 0);

        // R7 / R8 trigger with converter enabled
        adc_en_i = 1'b1;
        setup(16'd0, 16'd7);
        wr(A_CTL, ctl(1, 0, 4'b1011));
        waitn(7);
        rd(A_CNT, v); check("R7 count at match", v, 16'd7);
        check("R8 no pulse yet", conv_start_o, 0);
        waitn(1);
        rd(A_CNT, v); check("R7 counter reset", v, 0);
        check("R8 pulse", conv_start_o, 1);
        waitn(1);
        check("R8 pulse single", conv_start_o, 0);
        rd(A_FLG, v); check("R7 flags no overflow", v, 16'h0001);

        // R7 trigger at all ones
        setup(16'hFFF0, 16'hFFFF);
        wr(A_CTL, ctl(1, 0, 4'b1011));
        waitn(16);
        rd(A_CNT, v); check("R7 all-ones reset", v, 0);
        check("R8 pulse at all ones", conv_start_o, 1);
        waitn(4);
        rd(A_CNT, v); check("R7 after reset", v, 16'd4);
        rd(A_FLG, v); check("R7 no overflow at all ones", v, 16'h0001);

        // R8 converter disabled
        adc_en_i = 1'b0;
        setup(16'd0, 16'd5);
        wr(A_CTL, ctl(1, 0, 4'b1011));
        begin
            int pulses = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (conv_start_o) pulses++;
            end
            check("R8 no pulse when disabled", pulses, 0);
        end
        rd(A_CNT, v);
        check("R8 reset without converter", {15'd0, v <= 16'd5}, 1);

        // random: trigger periods
        adc_en_i = 1'b1;
        for (int it = 0; it < 8; it++) begin
            logic [15:0] c;
            int gap, guard;
            c = 16'(1 + ($urandom % 30));
            setup(16'd0, c);
            wr(A_CTL, ctl(1, 0, 4'b1011));
            guard = 0;
            while (!conv_start_o && guard < 100) begin @(negedge clk); guard++; end
            gap = 0;
            do begin @(negedge clk); gap++; end while (!conv_start_o && gap < 100);
            check("R7 random period", gap, int'(c) + 1);
        end

        // random: set/clear actions
        pin_model = pin_drv_o;
        for (int it = 0; it < 10; it++) begin
            logic [15:0] c;
            logic [3:0]  m;
            c = 16'(5 + ($urandom % 50));
            m = ($urandom % 2 == 0) ? 4'b1000 : 4'b1001;
            setup(16'd0, c);
            wr(A_CTL, ctl(1, 1, m));
            waitn(int'(c));
            check("R5 random before match", pin_drv_o, pin_model);
            waitn(1);
            pin_model = exp_latch(pin_model, m);
            check("R5 random after match", pin_drv_o, pin_model);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule